// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Lines

This block gathers 32 level-sensitive request lines from peripherals and presents them to a processor core as one interrupt request wire and an 8-bit vector number. Request lines 1 to 29 feed a pending word, which is gated by an enable mask that software writes. Lines 30 and 31 skip the mask entirely and drive a separate non-maskable request output. Line 0 has no function.

The block does not rank sources by priority. When exactly one enabled source is pending, the vector names that source directly. When several enabled sources are pending together, the vector takes one shared code, and software reads the masked pending word to decide which source to serve first. A small word-addressed register port gives software the mask, the raw and masked pending words, the non-maskable status, and a reserved word that reads as zero.

The vector, the request wire and the non-maskable output are all registered. They change on the same clock edge that captures the new input levels or the new mask value, so what software reads back always matches the outputs.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Word index 0 (byte address bits [4:2] equal to 0) holds the 32-bit enable mask. A write with regWrEn high stores regWrData, and a read returns the stored value.
- R2: A write to any word index other than 0 does not change the mask.
- R3: The read index is the byte address shifted right by two, and address bits [1:0] are ignored. The words are:
  - index 1: raw pending word
  - index 2: masked pending word, equal to raw AND mask
  - index 3: non-maskable status word
  - index 4: reserved word, reads 0
  - indices 5 to 7: read 0
- R4: On each clock edge, raw pending bit n-1 takes the level of request line n, for n from 1 to 29. Line 0 has no effect, and raw bits 29 to 31 always read 0.
- R5: When exactly one masked pending bit i is set, vecOut is 8'h31+i and irqOut is high.
- R6: When two or more masked pending bits are set, vecOut is 8'h30 and irqOut is high.
- R7: When no masked pending bit is set, vecOut is 0 and irqOut is low.
- R8: On each clock edge, status bits 30 and 31 take the levels of lines 30 and 31. All other status bits read 0. nmiOut is high when either status bit is set. The mask has no effect on these bits or on nmiOut, and these lines never appear in the raw pending word.
- R9: A synchronous reset clears the mask, the pending words and the status word, and drives vecOut to 0 and irqOut and nmiOut low.
- R10: A mask write and a request change take effect on vecOut and irqOut at the same clock edge that updates the readable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the word at regAddr (combinational) |
| reqLines | input | 32 | Level-sensitive request lines, synchronous to clk |
| irqOut | output | 1 | Maskable interrupt request to the core |
| nmiOut | output | 1 | Non-maskable interrupt request to the core |
| vecOut | output | 8 | Interrupt vector number |

## Verification
The bench targets four kinds of mistake:

- **Off-by-one line mapping.** Every single line is swept alone and every pair of lines is swept together. A design that shifted the line-to-bit mapping would report the wrong raw bit and a vector one away from the expected one. A design that checked only whether any bit was set would report a single-source vector where the shared code 8'h30 belongs.
- **Mask and non-maskable routing.** The mask is swept one bit at a time with all lines active. The non-maskable lines are driven with the mask cleared. A design that masked the non-maskable lines would stay silent, and one that let lines 30 and 31 into the pending word would raise an ordinary request.
- **Write decoding.** Writes to the read-only indices must leave the mask unchanged. A design that decoded the address loosely would overwrite the mask.
- **Timing.** The vector is checked on the edge of a mask write. A design that derived the vector from the already registered mask would lag one cycle behind the readable registers.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_COUNT = 5;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_NMI    = 3'd3,
    SEL_RSVD   = 3'd4,
    SEL_NONE   = 3'd5
  } regSel_e;

  typedef struct packed {
    logic    maskWr;
    regSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic [1:0]       addrLowUnused;

  assign wordIdx       = regAddr[ADDR_W-1:2];
  assign addrLowUnused = regAddr[1:0];

  always_comb begin
    strobes.maskWr = regWrEn && (wordIdx == '0);
    case (wordIdx)
      IDX_W'(0): strobes.rdSel = SEL_MASK;
      IDX_W'(1): strobes.rdSel = SEL_RAW;
      IDX_W'(2): strobes.rdSel = SEL_MASKED;
      IDX_W'(3): strobes.rdSel = SEL_NMI;
      IDX_W'(4): strobes.rdSel = SEL_RSVD;
      default:   strobes.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/vic_vec_encoder.sv
module vic_vec_encoder #(
  parameter int              WIDTH  = 32,
  parameter int              VEC_W  = 8,
  parameter logic [VEC_W-1:0] SHARED = 8'h30,
  parameter logic [VEC_W-1:0] BASE   = 8'h31
) (
  input  logic [WIDTH-1:0] pend,
  output logic [VEC_W-1:0] vecCode,
  output logic             anyPend
);
  logic             multi;
  logic [VEC_W-1:0] lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend[i]) lowIdx = VEC_W'(i);
    end
  end

  assign anyPend = |pend;
  assign multi   = |(pend & (pend - WIDTH'(1)));

  always_comb begin
    if (!anyPend)   vecCode = '0;
    else if (multi) vecCode = SHARED;
    else            vecCode = BASE + lowIdx;
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int VEC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] reqLines,
  output logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    maskReg,
  output logic [DATA_W-1:0]    rawPend,
  output logic [DATA_W-1:0]    nmiStat,
  output logic                 irqOut,
  output logic                 nmiOut,
  output logic [VEC_W-1:0]     vecOut
);
  localparam int VEC_LINES = NUM_LINES - NMI_LINES;

  logic [DATA_W-1:0] nextRaw;
  logic [DATA_W-1:0] nextNmi;
  logic [DATA_W-1:0] nextMask;
  logic [DATA_W-1:0] nextMasked;
  logic [VEC_W-1:0]  nextVec;
  logic              nextAny;
  logic              lineZeroUnused;

  assign lineZeroUnused = reqLines[0];

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : gRaw
      if (g < VEC_LINES - 1) begin : gLive
        assign nextRaw[g] = reqLines[g+1];
      end else begin : gZero
        assign nextRaw[g] = 1'b0;
      end
    end
    for (g = 0; g < DATA_W; g++) begin : gNmi
      if (g >= VEC_LINES && g < NUM_LINES) begin : gLive
        assign nextNmi[g] = reqLines[g];
      end else begin : gZero
        assign nextNmi[g] = 1'b0;
      end
    end
  endgenerate

  assign nextMask   = strobes.maskWr ? wrData : maskReg;
  assign nextMasked = nextRaw & nextMask;

  vic_vec_encoder #(
    .WIDTH(DATA_W),
    .VEC_W(VEC_W)
  ) uEnc (
    .pend   (nextMasked),
    .vecCode(nextVec),
    .anyPend(nextAny)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= '0;
      rawPend <= '0;
      nmiStat <= '0;
      vecOut  <= '0;
      irqOut  <= 1'b0;
      nmiOut  <= 1'b0;
    end else begin
      maskReg <= nextMask;
      rawPend <= nextRaw;
      nmiStat <= nextNmi;
      vecOut  <= nextVec;
      irqOut  <= nextAny;
      nmiOut  <= |nextNmi;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_MASK:   rdData = maskReg;
      SEL_RAW:    rdData = rawPend;
      SEL_MASKED: rdData = rawPend & maskReg;
      SEL_NMI:    rdData = nmiStat;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 32,
  parameter int NMI_LINES = 2,
  parameter int VEC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_LINES-1:0] reqLines,
  output logic                 irqOut,
  output logic                 nmiOut,
  output logic [VEC_W-1:0]     vecOut
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] rawPend;
  logic [DATA_W-1:0] nmiStat;

  vic_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobes(strobes)
  );

  vic_datapath #(
    .DATA_W   (DATA_W),
    .NUM_LINES(NUM_LINES),
    .NMI_LINES(NMI_LINES),
    .VEC_W    (VEC_W)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (regWrData),
    .reqLines(reqLines),
    .rdData  (regRdData),
    .maskReg (maskReg),
    .rawPend (rawPend),
    .nmiStat (nmiStat),
    .irqOut  (irqOut),
    .nmiOut  (nmiOut),
    .vecOut  (vecOut)
  );
endmodule

// File: rtl/vec_irq_ctrl_checker.sv
module vec_irq_ctrl_checker (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  regAddr,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] reqLines,
  input logic [31:0] maskReg,
  input logic [31:0] rawPend,
  input logic [31:0] nmiStat,
  input logic        irqOut,
  input logic        nmiOut,
  input logic [7:0]  vecOut
);
  logic [31:0] masked;
  logic [7:0]  vecIdx;
  assign masked = rawPend & maskReg;
  assign vecIdx = vecOut - 8'h31;

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr[4:2] == 3'd0) |=> maskReg == $past(regWrData)); // R1
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr[4:2] != 3'd0) |=> $stable(maskReg)); // R2
  AST_RAW_FOLLOWS_LINES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rawPend[0] == $past(reqLines[1])) && (rawPend[28] == $past(reqLines[29]))
             && (rawPend[31:29] == 3'b0)); // R4
  AST_SINGLE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ($countones(masked) == 1) |-> (irqOut && vecOut >= 8'h31 && vecIdx < 8'd32
                                   && masked[vecIdx[4:0]])); // R5
  AST_SHARED_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ($countones(masked) > 1) |-> (irqOut && vecOut == 8'h30)); // R6
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ($countones(masked) == 0) |-> (!irqOut && vecOut == 8'h00)); // R7
  AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nmiOut == $past(|reqLines[31:30])) && (nmiStat[29:0] == 30'b0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irqOut && !nmiOut && vecOut == 8'h00 && maskReg == 32'b0)); // R9
endmodule

bind vec_irq_ctrl vec_irq_ctrl_checker uChk (
  .clk      (clk),
  .rst      (rst),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .reqLines (reqLines),
  .maskReg  (maskReg),
  .rawPend  (rawPend),
  .nmiStat  (nmiStat),
  .irqOut   (irqOut),
  .nmiOut   (nmiOut),
  .vecOut   (vecOut)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] reqLines = '0;
  logic        irqOut;
  logic        nmiOut;
  logic [7:0]  vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqLines(reqLines),
    .irqOut(irqOut), .nmiOut(nmiOut), .vecOut(vecOut)
  );

  function automatic logic [31:0] expRaw(logic [31:0] r);
    return (r >> 1) & 32'h1FFF_FFFF;
  endfunction

  function automatic logic [7:0] expVec(logic [31:0] m);
    int cnt = $countones(m);
    if (cnt == 0) return 8'h00;
    if (cnt > 1)  return 8'h30;
    for (int i = 0; i < 32; i++) if (m[i]) return 8'h31 + 8'(i);
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeReg(logic [4:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] lfsrA;
    logic [31:0] lfsrB;
    lfsrA = 32'hACE1_2345;
    lfsrB = 32'h1357_9BDF;

    // R9 reset state
    repeat (3) tick();
    rst = 1'b0;
    check("R9 vec", {24'b0, vecOut}, 0);
    check("R9 irq", {31'b0, irqOut}, 0);
    check("R9 nmi", {31'b0, nmiOut}, 0);
    readReg(5'd0, rd); check("R9 mask", rd, 0);

    // R1 mask read/write, R3 low address bits ignored
    writeReg(5'd0, 32'hDEAD_BEEF);
    readReg(5'd0, rd); check("R1 mask readback", rd, 32'hDEAD_BEEF);
    readReg(5'd3, rd); check("R3 low bits ignored", rd, 32'hDEAD_BEEF);

    // R2 writes to other indices ignored
    for (int a = 1; a < 8; a++) begin
      writeReg(5'(a * 4), 32'h1234_5678);
      readReg(5'd0, rd); check("R2 ro write ignored", rd, 32'hDEAD_BEEF);
    end

    // R4/R5 single line sweep with full mask
    writeReg(5'd0, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      reqLines = 32'h1 << n;
      tick();
      readReg(5'd4, rd); check("R4 raw word", rd, expRaw(reqLines));
      check("R5 single vec", {24'b0, vecOut}, {24'b0, expVec(expRaw(reqLines))});
      check("R5 irq", {31'b0, irqOut}, {31'b0, |expRaw(reqLines)});
    end

    // R6 every pair of vector lines
    for (int i = 1; i < 30; i++) begin
      for (int j = i + 1; j < 30; j++) begin
        reqLines = (32'h1 << i) | (32'h1 << j);
        tick();
        check("R6 shared vec", {24'b0, vecOut}, 32'h30);
        check("R6 irq", {31'b0, irqOut}, 1);
      end
    end

    // R5/R7/R10 mask sweep with all lines active, vector valid on the write edge
    reqLines = 32'h3FFF_FFFE;
    tick();
    for (int k = 0; k < 32; k++) begin
      writeReg(5'd0, 32'h1 << k);
      check("R10 vec on mask edge", {24'b0, vecOut},
            {24'b0, expVec(expRaw(reqLines) & (32'h1 << k))});
      readReg(5'd8, rd); check("R3 masked word", rd, expRaw(reqLines) & (32'h1 << k));
    end
    writeReg(5'd0, 32'h0);
    check("R7 idle vec", {24'b0, vecOut}, 0);
    check("R7 idle irq", {31'b0, irqOut}, 0);

    // R8 non-maskable lines with mask cleared
    for (int c = 0; c < 4; c++) begin
      reqLines = 32'(c) << 30;
      tick();
      check("R8 nmi out", {31'b0, nmiOut}, {31'b0, (c != 0)});
      check("R8 irq stays low", {31'b0, irqOut}, 0);
      readReg(5'd12, rd); check("R8 nmi word", rd, 32'(c) << 30);
      readReg(5'd4, rd);  check("R8 raw clean", rd, 0);
    end

    // R3 reserved and out-of-range indices
    for (int a = 4; a < 8; a++) begin
      readReg(5'(a * 4 + 1), rd); check("R3 zero word", rd, 0);
    end

    // Mixed patterns: mask write and request change on the same edge
    for (int t = 0; t < 400; t++) begin
      lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
      lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      reqLines = (t % 3 == 0) ? (32'h1 << (lfsrA[4:0])) : lfsrA;
      writeReg(5'd0, (t % 4 == 1) ? (32'h1 << lfsrB[4:0]) : lfsrB);
      check("R10 vec mixed", {24'b0, vecOut}, {24'b0, expVec(expRaw(reqLines) & regWrData)});
      check("R5 irq mixed", {31'b0, irqOut}, {31'b0, |(expRaw(reqLines) & regWrData)});
      check("R8 nmi mixed", {31'b0, nmiOut}, {31'b0, |reqLines[31:30]});
      readReg(5'd8, rd); check("R3 masked mixed", rd, expRaw(reqLines) & regWrData);
    end

    // R9 reset mid-run with active lines
    writeReg(5'd0, 32'hFFFF_FFFF);
    reqLines = 32'hFFFF_FFFF;
    rst = 1'b1;
    tick();
    check("R9 mid vec", {24'b0, vecOut}, 0);
    check("R9 mid irq", {31'b0, irqOut}, 0);
    check("R9 mid nmi", {31'b0, nmiOut}, 0);
    readReg(5'd0, rd); check("R9 mid mask", rd, 0);
    rst = 1'b0;
    tick();
    check("R7 mask clear after reset", {31'b0, irqOut}, 0);
    check("R8 nmi after reset", {31'b0, nmiOut}, 1);

    finishRun();
  end
endmodule